// File: doc/BRIEF.md
# Simulation Test-Control Register Block

This block is a small write-only register window for a test program that runs on a soft CPU inside a simulation. The program uses it to report a pass or fail verdict, to name the test being run and to ask for the simulation to end. Three word registers sit in a 12-byte window at a parameterised base address. A write to the shutdown word pulses a shutdown request. A write to the verdict word pulses a result strobe and carries a fail flag. A write to the name-pointer word starts a fetch of a fixed 16-byte name string from system memory into a buffer. The last byte of that buffer is always zero.

Both edges of the block use valid/ready. On the slave side a write is taken in the cycle where `req_valid` and `req_ready` are both high. The CPU must hold its request stable until that cycle, and `req_ready` stays low for as long as a name fetch runs. On the memory side the block raises `mem_req_valid` for one byte address and holds it, with the address unchanged, until `mem_req_ready` accepts it. It then waits for `mem_rsp_valid` before it issues the next address. The responder must not drive `mem_rsp_valid` unless a request is outstanding.

Top module: `simctl_regs`

## Requirements
- R1: A write is legal only when `req_write` is 1 and `req_size` equals 4 (`req_size` gives the access width in bytes: 1, 2 or 4). A read, or a 1- or 2-byte write, raises `acc_err_o` and changes no state, so no pulse fires, the fail flag is unchanged and no fetch starts.
- R2: The register index is `req_addr[3:2]` relative to `BASE`: 0 is shutdown, 1 is verdict and 2 is name pointer. An address whose bits above bit 3 differ from `BASE`, with a non-zero `req_addr[1:0]`, or with index 3 raises `acc_err_o` and changes no state.
- R3: An accepted legal write to index 0, with any data, makes `shutdown_o` high for exactly the one cycle after the accepting edge.
- R4: An accepted legal write to index 1 stores the data. `result_valid_o` is high for the one following cycle. `result_fail_o` is 1 when the stored value is non-zero and 0 when it is zero, and it changes only together with a `result_valid_o` pulse.
- R5: An accepted legal write to index 2 starts 16 byte reads at the addresses ptr, ptr+1, ... ptr+15, in that order and wrapping modulo 2^32. Each request stays valid, with its address unchanged, until it is accepted.
- R6: Byte k of the fetched string is placed in `name_buf_o[8k+7:8k]`. Byte 15 is always stored as zero, whatever memory returns.
- R7: From the cycle after a pointer write is accepted until the 16th response arrives, `busy_o` is 1 and `req_ready` is 0. A write presented in that time waits and is accepted only after the fetch ends.
- R8: Reset (`rst_n` low, asynchronous) clears the pointer, the stored verdict, the whole name buffer and all pulses, and leaves `req_ready` at 1.
- R9: `acc_err_o` is a one-cycle pulse in the cycle after the rejected access is accepted. At most one of `shutdown_o`, `result_valid_o` and `acc_err_o` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Slave access valid |
| req_ready | output | 1 | Slave access ready (low while busy) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Byte address |
| req_size | input | 3 | Access width in bytes |
| req_wdata | input | 32 | Write data |
| mem_req_valid | output | 1 | Byte read request valid |
| mem_req_ready | input | 1 | Byte read request accepted |
| mem_req_addr | output | 32 | Byte read address |
| mem_rsp_valid | input | 1 | Read byte returned |
| mem_rsp_data | input | 8 | Returned byte |
| shutdown_o | output | 1 | Shutdown request pulse |
| result_valid_o | output | 1 | Verdict strobe |
| result_fail_o | output | 1 | Stored verdict is a failure |
| acc_err_o | output | 1 | Rejected access pulse |
| busy_o | output | 1 | Name fetch in progress |
| name_buf_o | output | 128 | Name buffer, byte k at bits 8k+7:8k |

## Verification
The bench attacks the stall window by presenting a verdict write right behind a pointer write. A block that let that write through early would pulse `result_valid_o` while `busy_o` is still high. It also stalls memory requests and delays responses at random, so a design that moved the address before the request was accepted, or lost a byte, would return a wrong buffer or a wrong address order. Pointers near the top of the address space exercise wrap-around, and memory data that is non-zero at byte 15 catches a terminator that was never forced. Reads, narrow writes, misaligned and out-of-window addresses are mixed between legal writes, so a decoder that leaks state would change the fail flag or start a fetch.

// File: rtl/simctl_pkg.sv
package simctl_pkg;
  localparam int DATA_W     = 32;
  localparam int WORD_BYTES = 4;

  typedef enum logic [1:0] {
    IDX_SHUTDOWN = 2'd0,
    IDX_VERDICT  = 2'd1,
    IDX_NAMEPTR  = 2'd2,
    IDX_NONE     = 2'd3
  } reg_idx_e;

  typedef enum logic [1:0] {
    F_IDLE = 2'd0,
    F_REQ  = 2'd1,
    F_WAIT = 2'd2
  } fetch_st_e;
endpackage

// File: rtl/simctl_decode.sv
module simctl_decode
  import simctl_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] BASE = 32'hFFFF_0000
) (
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [2:0]        req_size,
  output reg_idx_e          idx,
  output logic              legal
);
  logic in_window, aligned, word_write;

  always_comb begin
    in_window  = (req_addr[ADDR_W-1:4] == BASE[ADDR_W-1:4]);
    aligned    = (req_addr[1:0] == 2'b00);
    word_write = req_write && (req_size == 3'(WORD_BYTES));
    idx        = reg_idx_e'(req_addr[3:2]);
    legal      = word_write && in_window && aligned && (idx != IDX_NONE);
  end
endmodule

// File: rtl/simctl_report.sv
module simctl_report
  import simctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc,
  input  logic              legal,
  input  reg_idx_e          idx,
  input  logic [DATA_W-1:0] wdata,
  output logic              shutdown_o,
  output logic              result_valid_o,
  output logic              result_fail_o,
  output logic              acc_err_o,
  output logic              fetch_start
);
  logic [DATA_W-1:0] verdict_q;
  logic take;

  assign take          = acc && legal;
  assign fetch_start   = take && (idx == IDX_NAMEPTR);
  assign result_fail_o = |verdict_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shutdown_o     <= 1'b0;
      result_valid_o <= 1'b0;
      acc_err_o      <= 1'b0;
      verdict_q      <= '0;
    end else begin
      shutdown_o     <= take && (idx == IDX_SHUTDOWN);
      result_valid_o <= take && (idx == IDX_VERDICT);
      acc_err_o      <= acc && !legal;
      if (take && (idx == IDX_VERDICT)) verdict_q <= wdata;
    end
  end
endmodule

// File: rtl/simctl_fetch.sv
module simctl_fetch
  import simctl_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int NAME_LEN = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [ADDR_W-1:0]     start_addr,
  output logic                  mem_req_valid,
  input  logic                  mem_req_ready,
  output logic [ADDR_W-1:0]     mem_req_addr,
  input  logic                  mem_rsp_valid,
  input  logic [7:0]            mem_rsp_data,
  output logic                  busy,
  output logic [8*NAME_LEN-1:0] name_buf
);
  localparam int CNT_W = $clog2(NAME_LEN);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(NAME_LEN - 1);

  fetch_st_e         st_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] ptr_q;
  logic              byte_we;

  assign busy          = (st_q != F_IDLE);
  assign mem_req_valid = (st_q == F_REQ);
  assign mem_req_addr  = ptr_q + ADDR_W'(cnt_q);
  assign byte_we       = (st_q == F_WAIT) && mem_rsp_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= F_IDLE;
      cnt_q <= '0;
      ptr_q <= '0;
    end else begin
      case (st_q)
        F_IDLE: if (start) begin
          ptr_q <= start_addr;
          cnt_q <= '0;
          st_q  <= F_REQ;
        end
        F_REQ: if (mem_req_ready) st_q <= F_WAIT;
        F_WAIT: if (mem_rsp_valid) begin
          if (cnt_q == LAST) st_q <= F_IDLE;
          else begin
            cnt_q <= cnt_q + 1'b1;
            st_q  <= F_REQ;
          end
        end
        default: st_q <= F_IDLE;
      endcase
    end
  end

  for (genvar i = 0; i < NAME_LEN; i++) begin : g_byte
    if (i == NAME_LEN - 1) begin : g_term
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) name_buf[8*i +: 8] <= 8'h00;
        else        name_buf[8*i +: 8] <= 8'h00;
      end
    end else begin : g_data
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) name_buf[8*i +: 8] <= 8'h00;
        else if (byte_we && cnt_q == CNT_W'(i)) name_buf[8*i +: 8] <= mem_rsp_data;
      end
    end
  end
endmodule

// File: rtl/simctl_regs.sv
module simctl_regs
  import simctl_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int NAME_LEN = 16,
  parameter logic [ADDR_W-1:0] BASE = 32'hFFFF_0000
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic                  req_write,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [2:0]            req_size,
  input  logic [DATA_W-1:0]     req_wdata,
  output logic                  mem_req_valid,
  input  logic                  mem_req_ready,
  output logic [ADDR_W-1:0]     mem_req_addr,
  input  logic                  mem_rsp_valid,
  input  logic [7:0]            mem_rsp_data,
  output logic                  shutdown_o,
  output logic                  result_valid_o,
  output logic                  result_fail_o,
  output logic                  acc_err_o,
  output logic                  busy_o,
  output logic [8*NAME_LEN-1:0] name_buf_o
);
  reg_idx_e idx;
  logic     legal, acc, fetch_start;

  assign req_ready = !busy_o;
  assign acc       = req_valid && req_ready;

  simctl_decode #(.ADDR_W(ADDR_W), .BASE(BASE)) u_dec (
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_size  (req_size),
    .idx       (idx),
    .legal     (legal)
  );

  simctl_report u_rep (
    .clk            (clk),
    .rst_n          (rst_n),
    .acc            (acc),
    .legal          (legal),
    .idx            (idx),
    .wdata          (req_wdata),
    .shutdown_o     (shutdown_o),
    .result_valid_o (result_valid_o),
    .result_fail_o  (result_fail_o),
    .acc_err_o      (acc_err_o),
    .fetch_start    (fetch_start)
  );

  simctl_fetch #(.ADDR_W(ADDR_W), .NAME_LEN(NAME_LEN)) u_fetch (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (fetch_start),
    .start_addr    (req_wdata[ADDR_W-1:0]),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data),
    .busy          (busy_o),
    .name_buf      (name_buf_o)
  );
endmodule

// File: rtl/simctl_chk.sv
module simctl_chk #(
  parameter int ADDR_W   = 32,
  parameter int NAME_LEN = 16
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  req_valid,
  input logic                  req_ready,
  input logic                  mem_req_valid,
  input logic                  mem_req_ready,
  input logic [ADDR_W-1:0]     mem_req_addr,
  input logic                  shutdown_o,
  input logic                  result_valid_o,
  input logic                  result_fail_o,
  input logic                  acc_err_o,
  input logic                  busy_o,
  input logic [8*NAME_LEN-1:0] name_buf_o
);
  // R7
  stall_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !req_ready);

  // R5
  memreq_in_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> busy_o);

  // R5
  memreq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  // R6
  name_term_chk: assert property (@(posedge clk) disable iff (!rst_n)
    name_buf_o[8*NAME_LEN-1 -: 8] == 8'h00);

  // R9
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({shutdown_o, result_valid_o, acc_err_o}));

  // R3
  shutdown_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown_o |-> $past(req_valid && req_ready));

  // R4
  fail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !result_valid_o |-> $stable(result_fail_o));
endmodule

bind simctl_regs simctl_chk #(.ADDR_W(ADDR_W), .NAME_LEN(NAME_LEN)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .req_valid      (req_valid),
  .req_ready      (req_ready),
  .mem_req_valid  (mem_req_valid),
  .mem_req_ready  (mem_req_ready),
  .mem_req_addr   (mem_req_addr),
  .shutdown_o     (shutdown_o),
  .result_valid_o (result_valid_o),
  .result_fail_o  (result_fail_o),
  .acc_err_o      (acc_err_o),
  .busy_o         (busy_o),
  .name_buf_o     (name_buf_o)
);

// File: tb/simctl_regs_test.sv
module simctl_regs_test;
  localparam logic [31:0] BASE = 32'hFFFF_0000;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0, req_write = 1'b0;
  logic [31:0]  req_addr = '0, req_wdata = '0;
  logic [2:0]   req_size = 3'd4;
  logic         mem_req_ready = 1'b0, mem_rsp_valid = 1'b0;
  logic [7:0]   mem_rsp_data = '0;
  logic         req_ready, mem_req_valid, shutdown_o, result_valid_o;
  logic         result_fail_o, acc_err_o, busy_o;
  logic [31:0]  mem_req_addr;
  logic [127:0] name_buf_o;

  int n_chk = 0, n_fail = 0;
  logic        exp_fail = 1'b0;
  logic [31:0] fetch_base = '0;
  int          fetch_k = 0;

  always #10 clk = ~clk;

  simctl_regs uut (.*);

  function automatic logic [7:0] memf(input logic [31:0] a);
    return (a[7:0] * 8'd3) ^ a[15:8] ^ 8'hA5;
  endfunction

  function automatic logic [127:0] exp_name(input logic [31:0] p);
    logic [127:0] v = '0;
    for (int k = 0; k < 15; k++) v[8*k +: 8] = memf(p + 32'(k));
    return v;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // memory responder and address monitor, all on the falling edge
  initial begin
    bit pend = 0;
    int dly = 0;
    logic [31:0] paddr = '0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      if (pend) begin
        if (dly == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = memf(paddr);
          pend = 0;
        end else dly--;
      end
      mem_req_ready = ($urandom % 3) != 0;
      if (mem_req_valid && mem_req_ready && rst_n) begin
        // R5 address order
        chk(mem_req_addr == fetch_base + 32'(fetch_k), "R5 fetch address",
            128'(mem_req_addr), 128'(fetch_base + 32'(fetch_k)));
        fetch_k++;
        pend  = 1;
        dly   = $urandom % 3;
        paddr = mem_req_addr;
      end
    end
  end

  task automatic bus(input bit wr, input logic [31:0] a, input logic [31:0] d, input logic [2:0] sz);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_size = sz;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic pulses(input string tag, input bit sd, input bit rv, input bit er);
    chk(shutdown_o == sd && result_valid_o == rv && acc_err_o == er, tag,
        128'({shutdown_o, result_valid_o, acc_err_o}), 128'({sd, rv, er}));
  endtask

  task automatic next_quiet(input string tag);
    @(negedge clk);
    pulses(tag, 0, 0, 0);
  endtask

  task automatic do_fetch(input logic [31:0] p);
    fetch_base = p; fetch_k = 0;
    bus(1, BASE + 32'h8, p, 3'd4);
    chk(busy_o && !req_ready, "R7 busy after pointer write", 128'({busy_o, req_ready}), 128'(2'b10));
    while (busy_o) @(negedge clk);
    chk(fetch_k == 16, "R5 sixteen reads", 128'(fetch_k), 128'(16));
    chk(name_buf_o == exp_name(p), "R6 name buffer", name_buf_o, exp_name(p));
  endtask

  initial begin
    #200000000;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8 reset state
    chk(name_buf_o == 0 && !result_fail_o && !busy_o && req_ready, "R8 reset state",
        128'({name_buf_o[7:0], result_fail_o, busy_o, req_ready}), 128'(1));
    pulses("R8 reset pulses", 0, 0, 0);

    // R3 shutdown with zero data, one-cycle pulse
    bus(1, BASE, 32'h0, 3'd4);
    pulses("R3 shutdown pulse", 1, 0, 0);
    next_quiet("R3 shutdown one cycle");

    // R4 fail then pass
    bus(1, BASE + 32'h4, 32'h8000_0000, 3'd4); exp_fail = 1;
    pulses("R4 verdict strobe", 0, 1, 0);
    chk(result_fail_o == 1, "R4 fail flag", 128'(result_fail_o), 128'(1));
    next_quiet("R4 strobe one cycle");
    bus(1, BASE + 32'h4, 32'h0, 3'd4); exp_fail = 0;
    chk(result_fail_o == 0, "R4 pass flag", 128'(result_fail_o), 128'(0));

    // R1 narrow write and read rejected
    bus(1, BASE + 32'h4, 32'h1, 3'd2);
    pulses("R1 narrow write error", 0, 0, 1);
    chk(result_fail_o == exp_fail, "R1 narrow write no effect", 128'(result_fail_o), 128'(exp_fail));
    next_quiet("R9 error one cycle");
    bus(0, BASE, 32'h0, 3'd4);
    pulses("R1 read rejected", 0, 0, 1);

    // R6 R5 fetch, then R1 narrow pointer write starts nothing
    do_fetch(32'h0000_1230);
    bus(1, BASE + 32'h8, 32'h0000_4000, 3'd1);
    pulses("R1 narrow pointer error", 0, 0, 1);
    chk(!busy_o && name_buf_o == exp_name(32'h0000_1230), "R1 no fetch",
        name_buf_o, exp_name(32'h0000_1230));

    // R2 out-of-range offsets
    bus(1, BASE + 32'hC, 32'h5, 3'd4);
    pulses("R2 index 3 error", 0, 0, 1);
    bus(1, BASE + 32'h6, 32'h5, 3'd4);
    pulses("R2 misaligned error", 0, 0, 1);
    bus(1, BASE + 32'h14, 32'h5, 3'd4);
    pulses("R2 outside window error", 0, 0, 1);
    chk(result_fail_o == exp_fail && !busy_o, "R2 no state change", 128'(result_fail_o), 128'(exp_fail));

    // R5 wrap around the top of the address space
    do_fetch(32'hFFFF_FFF8);

    // R7 write presented right behind a pointer write is stalled
    fetch_base = 32'h0000_0777; fetch_k = 0;
    bus(1, BASE + 32'h8, 32'h0000_0777, 3'd4);
    bus(1, BASE + 32'h4, 32'h3, 3'd4); exp_fail = 1;
    chk(!busy_o && fetch_k == 16, "R7 write stalled until fetch done", 128'(fetch_k), 128'(16));
    pulses("R7 stalled write strobe", 0, 1, 0);
    chk(name_buf_o == exp_name(32'h0000_0777), "R6 name after stall", name_buf_o, exp_name(32'h0000_0777));

    // random mix
    for (int i = 0; i < 60; i++) begin
      int kind = $urandom % 5;
      logic [31:0] d = ($urandom % 4 == 0) ? 32'h0 : $urandom;
      case (kind)
        0: begin bus(1, BASE, d, 3'd4); pulses("R3 random shutdown", 1, 0, 0); end
        1: begin bus(1, BASE + 32'h4, d, 3'd4); exp_fail = (d != 0);
                 pulses("R4 random verdict", 0, 1, 0); end
        2: begin bus(1, BASE + 32'hC + 32'(4 * ($urandom % 3)) * 32'h10, d, 3'd4);
                 pulses("R2 random bad offset", 0, 0, 1); end
        3: begin bus(($urandom % 2) == 1, BASE + 32'h4, d, ($urandom % 2) ? 3'd1 : 3'd2);
                 pulses("R1 random bad size", 0, 0, 1); end
        default: begin bus(0, BASE + 32'h4, d, 3'd4); pulses("R1 random read", 0, 0, 1); end
      endcase
      chk(result_fail_o == exp_fail, "R4 random fail flag", 128'(result_fail_o), 128'(exp_fail));
      if (i % 20 == 0) do_fetch($urandom);
    end

    // R8 reset in the middle of the run clears everything
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk(name_buf_o == 0 && !result_fail_o && req_ready, "R8 reset after use",
        name_buf_o, 128'(0));
    rst_n = 1'b1; exp_fail = 0;
    next_quiet("R8 quiet after reset");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule